// File: doc/BRIEF.md
# Power-Up Configuration Image Loader

After reset is released, this block reads a whole configuration image out of a serial 2-wire EEPROM and copies it, byte by byte, into the chip's internal configuration registers. It is the bus master. It sends the control byte with the write bit, sets the EEPROM word pointer to zero, issues a repeated START and the control byte with the read bit, and then reads the image in one sequential burst. The byte at image offset k goes to register k. The identity register and a parameterized range of status registers are read like every other byte, but they are never written.

Both bus lines are open-drain. The block only pulls SCL or SDA low, and the board resistors pull them high. The SCL rate comes from the system clock through a quarter-period divider, which bounds the whole load to a fixed number of bus periods. If the EEPROM does not acknowledge, the block ends the transfer with STOP, writes no register and flags that no image is present.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is high, both bus pull-downs are off and busy, done and no_eeprom are low. In the cycle after the first clock edge with reset low, busy is high, without any other trigger.
- R2: The bus transfer opens with a START and the byte {DEV_ADDR,0} (0xA0 by default), then sends a word-address byte of 0x00. After that come a repeated START and the byte {DEV_ADDR,1} (0xA1). Bytes are sent MSB first, and the slave's ACK is SDA low in the ninth clock.
- R3: Exactly NUM_REGS data bytes are read. The master acknowledges each of them except the last, which it NACKs (SDA released). A single STOP follows, for two STARTs in total.
- R4: Image byte k appears on reg_wdata with reg_addr = k during a one-cycle reg_we pulse. Writes come in strictly ascending address order, and each writable address is written exactly once.
- R5: Address ID_ADDR (1) and every address from STAT_LO to STAT_HI (248..255 by default) never receive reg_we. With defaults, this leaves 247 writes.
- R6: If any address or control byte is not acknowledged, reg_we never pulses. The block issues STOP, then raises done together with no_eeprom.
- R7: Busy stays high until STOP completes. Busy then falls and done rises in the same cycle. Done holds until the next reset, and busy and done are never high together.
- R8: Within a byte, the SCL period is 4*QTR_DIV clocks. The whole load ends within (9*NUM_REGS+400) SCL periods. At 200 MHz with the default divider, this is under 30 ms.
- R9: A reset asserted mid-load abandons the load. After release, the load restarts from offset 0 and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |
| reg_addr | output | $clog2(NUM_REGS) | Configuration register address |
| reg_wdata | output | 8 | Configuration register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished (sticky until reset) |
| no_eeprom | output | 1 | EEPROM did not acknowledge |

## Verification
A corrupt byte counter shows up at the register port on the very next strobe. It appears as an address out of ascending order or a write into a protected location. It also shifts where the NACK and the STOP fall, so the end of the load moves. A bit-engine phase error shows on the bus within one SCL period. It appears as a wrong control byte, a misplaced START or STOP, or a corrupted image byte seen at the register port. A sequencer stuck in a state leaves busy high past the period bound. A wrong acknowledge decision either writes registers after a refused address or flags a missing EEPROM when the EEPROM answered.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // Byte-level bus operations issued by the sequencer
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    // Bit engine phases
    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_START = 2'd1,
        EN_BITS  = 2'd2,
        EN_STOP  = 2'd3
    } eng_st_e;

    // Load sequence steps
    typedef enum logic [2:0] {
        SQ_START  = 3'd0,
        SQ_DEVW   = 3'd1,
        SQ_WADDR  = 3'd2,
        SQ_RSTART = 3'd3,
        SQ_DEVR   = 3'd4,
        SQ_READ   = 3'd5,
        SQ_STOP   = 3'd6,
        SQ_DONE   = 3'd7
    } seq_st_e;

    // One command to the bit engine
    typedef struct packed {
        bus_op_e    op;
        logic [7:0] wbyte;
        logic       nack;
    } bus_cmd_t;

    // Locations that must keep their hardware value
    function automatic logic is_locked(input int unsigned a, input int unsigned id,
                                       input int unsigned lo, input int unsigned hi);
        return (a == id) || ((a >= lo) && (a <= hi));
    endfunction

endpackage

// File: rtl/cfg_qtick.sv
module cfg_qtick #(
    parameter int unsigned DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_i2c_byte.sv
module cfg_i2c_byte
    import cfg_loader_pkg::*;
#(
    parameter int unsigned QTR_DIV = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  bus_cmd_t   cmd,
    input  logic       sda_in,
    output logic       scl_lvl,
    output logic       sda_lvl,
    output logic       op_done,
    output logic [7:0] rbyte,
    output logic       ack_ok
);
    localparam int unsigned LAST_BIT = 8;

    eng_st_e    st;
    bus_op_e    op;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       nack;
    logic       tick;
    logic       accept;
    logic       scl_n, sda_n;

    assign accept = go && (st == EN_IDLE);

    cfg_qtick #(.DIV(QTR_DIV)) u_qtick (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .tick (tick)
    );

    // Line levels per quarter of the current symbol
    always_comb begin
        scl_n = scl_lvl;
        sda_n = sda_lvl;
        unique case (st)
            EN_START: begin
                scl_n = (q == 2'd1) || (q == 2'd2);
                sda_n = (q <= 2'd1);
            end
            EN_STOP: begin
                scl_n = (q >= 2'd1);
                sda_n = (q >= 2'd2);
            end
            EN_BITS: begin
                scl_n = (q == 2'd1) || (q == 2'd2);
                if (bitn == 4'(LAST_BIT)) begin
                    sda_n = (op == OP_WRITE) ? 1'b1 : nack;
                end else begin
                    sda_n = (op == OP_WRITE) ? sh[7] : 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            op      <= OP_START;
            q       <= '0;
            bitn    <= '0;
            sh      <= '0;
            nack    <= 1'b0;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            op_done <= 1'b0;
            rbyte   <= '0;
            ack_ok  <= 1'b0;
        end else begin
            op_done <= 1'b0;
            scl_lvl <= scl_n;
            sda_lvl <= sda_n;
            if (st == EN_IDLE) begin
                if (go) begin
                    op   <= cmd.op;
                    sh   <= cmd.wbyte;
                    nack <= cmd.nack;
                    q    <= '0;
                    bitn <= '0;
                    unique case (cmd.op)
                        OP_START: st <= EN_START;
                        OP_STOP:  st <= EN_STOP;
                        default:  st <= EN_BITS;
                    endcase
                end
            end else if (tick) begin
                q <= q + 2'd1;
                if ((st == EN_BITS) && (q == 2'd2)) begin
                    if ((op == OP_WRITE) && (bitn == 4'(LAST_BIT))) begin
                        ack_ok <= ~sda_in;
                    end
                    if ((op == OP_READ) && (bitn < 4'(LAST_BIT))) begin
                        sh <= {sh[6:0], sda_in};
                    end
                end
                if (q == 2'd3) begin
                    if ((st == EN_BITS) && (bitn != 4'(LAST_BIT))) begin
                        bitn <= bitn + 4'd1;
                        if (op == OP_WRITE) begin
                            sh <= {sh[6:0], 1'b0};
                        end
                    end else begin
                        st      <= EN_IDLE;
                        op_done <= 1'b1;
                        rbyte   <= sh;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned NUM_REGS = 256,
    parameter int unsigned QTR_DIV  = 125,
    parameter logic [6:0]  DEV_ADDR = 7'h50,
    parameter int unsigned ID_ADDR  = 1,
    parameter int unsigned STAT_LO  = 248,
    parameter int unsigned STAT_HI  = 255
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        scl_oe,
    output logic                        sda_oe,
    input  logic                        sda_in,
    output logic [$clog2(NUM_REGS)-1:0] reg_addr,
    output logic [7:0]                  reg_wdata,
    output logic                        reg_we,
    output logic                        busy,
    output logic                        done,
    output logic                        no_eeprom
);
    localparam int unsigned AW = $clog2(NUM_REGS);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_REGS - 1);

    seq_st_e       sq;
    logic          issued;
    logic          go;
    bus_cmd_t      cmd;
    logic [AW-1:0] idx;
    logic          scl_lvl, sda_lvl;
    logic          op_done, ack_ok;
    logic [7:0]    rbyte;

    assign go = (sq != SQ_DONE) && !issued;

    always_comb begin
        cmd = '{op: OP_START, wbyte: 8'h00, nack: 1'b0};
        unique case (sq)
            SQ_DEVW:  cmd = '{op: OP_WRITE, wbyte: {DEV_ADDR, 1'b0}, nack: 1'b0};
            SQ_WADDR: cmd = '{op: OP_WRITE, wbyte: 8'h00, nack: 1'b0};
            SQ_DEVR:  cmd = '{op: OP_WRITE, wbyte: {DEV_ADDR, 1'b1}, nack: 1'b0};
            SQ_READ:  cmd = '{op: OP_READ, wbyte: 8'h00, nack: (idx == LAST_IDX)};
            SQ_STOP:  cmd = '{op: OP_STOP, wbyte: 8'h00, nack: 1'b0};
            default:  ;
        endcase
    end

    cfg_i2c_byte #(.QTR_DIV(QTR_DIV)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .cmd     (cmd),
        .sda_in  (sda_in),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .op_done (op_done),
        .rbyte   (rbyte),
        .ack_ok  (ack_ok)
    );

    assign scl_oe = ~scl_lvl;
    assign sda_oe = ~sda_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq        <= SQ_START;
            issued    <= 1'b0;
            idx       <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            no_eeprom <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (go) begin
                issued <= 1'b1;
            end
            if (!done) begin
                busy <= 1'b1;
            end
            if (op_done) begin
                issued <= 1'b0;
                unique case (sq)
                    SQ_START:  sq <= SQ_DEVW;
                    SQ_RSTART: sq <= SQ_DEVR;
                    SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
                        if (ack_ok) begin
                            sq <= (sq == SQ_DEVW)  ? SQ_WADDR :
                                  (sq == SQ_WADDR) ? SQ_RSTART : SQ_READ;
                        end else begin
                            no_eeprom <= 1'b1;
                            sq        <= SQ_STOP;
                        end
                    end
                    SQ_READ: begin
                        if (!is_locked(int'(idx), ID_ADDR, STAT_LO, STAT_HI)) begin
                            reg_we    <= 1'b1;
                            reg_addr  <= idx;
                            reg_wdata <= rbyte;
                        end
                        if (idx == LAST_IDX) begin
                            sq <= SQ_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    SQ_STOP: begin
                        sq   <= SQ_DONE;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk
    import cfg_loader_pkg::*;
#(
    parameter int unsigned NUM_REGS = 256,
    parameter int unsigned QTR_DIV  = 125,
    parameter int unsigned ID_ADDR  = 1,
    parameter int unsigned STAT_LO  = 248,
    parameter int unsigned STAT_HI  = 255
) (
    input logic                        clk,
    input logic                        rst,
    input logic [$clog2(NUM_REGS)-1:0] reg_addr,
    input logic                        reg_we,
    input logic                        busy,
    input logic                        done,
    input logic                        no_eeprom
);
    localparam int unsigned AW = $clog2(NUM_REGS);
    localparam longint unsigned LIMIT = (longint'(9 * NUM_REGS) + 400) * 4 * QTR_DIV;

    logic [AW-1:0] last_addr;
    logic          seen_wr;
    logic [31:0]   busy_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            seen_wr   <= 1'b0;
            busy_cyc  <= '0;
        end else begin
            if (reg_we) begin
                last_addr <= reg_addr;
                seen_wr   <= 1'b1;
            end
            if (busy) begin
                busy_cyc <= busy_cyc + 32'd1;
            end
        end
    end

    // R1
    start_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> busy);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R4
    write_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> busy);

    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && seen_wr) |-> (reg_addr > last_addr));

    // R5
    locked_skip_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !is_locked(int'(reg_addr), ID_ADDR, STAT_LO, STAT_HI));

    // R6
    absent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        no_eeprom |-> (!reg_we && !seen_wr));

    // R8
    load_time_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (longint'(busy_cyc) < LIMIT));
endmodule

bind cfg_image_loader cfg_image_loader_chk #(
    .NUM_REGS (NUM_REGS),
    .QTR_DIV  (QTR_DIV),
    .ID_ADDR  (ID_ADDR),
    .STAT_LO  (STAT_LO),
    .STAT_HI  (STAT_HI)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .busy      (busy),
    .done      (done),
    .no_eeprom (no_eeprom)
);

// File: tb/tb_cfg_image_loader.sv
`timescale 1ns/1ps
module tb_cfg_image_loader;
    localparam int NREG   = 256;
    localparam int QDIV   = 2;
    localparam int ID_A   = 1;
    localparam int ST_LO  = 248;
    localparam int ST_HI  = 255;
    localparam logic [6:0] DEV = 7'h50;
    localparam int BOUND  = (9 * NREG + 400) * 4 * QDIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       scl_oe, sda_oe, reg_we, busy, done, no_eeprom;
    logic [7:0] reg_addr, reg_wdata;
    logic       slave_low = 1'b0;
    wire        scl = scl_oe ? 1'b0 : 1'b1;
    wire        sda = (sda_oe || slave_low) ? 1'b0 : 1'b1;

    cfg_image_loader #(
        .NUM_REGS(NREG), .QTR_DIV(QDIV), .DEV_ADDR(DEV),
        .ID_ADDR(ID_A), .STAT_LO(ST_LO), .STAT_HI(ST_HI)
    ) dut (
        .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .busy(busy), .done(done), .no_eeprom(no_eeprom)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] img(input int k);
        return 8'((k * 37 + 11) ^ 8'h5A);
    endfunction

    // ---------------- EEPROM model ----------------
    typedef enum int {PH_IDLE, PH_CTRL, PH_WADDR, PH_TX} ph_e;
    ph_e        ph = PH_IDLE;
    bit         present = 1;
    int         pcnt = 0;
    logic [7:0] sh = 0, txb = 0, ptr = 0;
    logic       pscl = 1, psda = 1;
    bit         ctrl_ack = 0, m_ack = 0;
    int         start_n = 0, stop_n = 0, ack_n = 0, nack_n = 0, nack_at = -1, tx_n = 0;
    logic [7:0] ctrl_log [4];
    int         ctrl_n = 0;
    logic [7:0] waddr_log = 8'hFF;

    task automatic load_tx();
        txb = img(int'(ptr));
        ptr = ptr + 8'd1;
        tx_n++;
        slave_low = ~txb[7];
    endtask

    always @(scl, sda, rst) begin
        if (rst) begin
            ph = PH_IDLE; slave_low = 1'b0; pcnt = 0;
        end else if ((sda !== psda) && (scl === 1'b1) && (pscl === 1'b1)) begin
            if (sda === 1'b0) begin start_n++; ph = PH_CTRL; pcnt = 0; slave_low = 1'b0; end
            else begin stop_n++; ph = PH_IDLE; slave_low = 1'b0; end
        end else if ((scl === 1'b1) && (pscl === 1'b0) && (ph != PH_IDLE)) begin
            pcnt++;
            if ((ph == PH_CTRL || ph == PH_WADDR) && pcnt <= 8) sh = {sh[6:0], sda};
            if (ph == PH_TX && pcnt == 9) begin
                m_ack = (sda === 1'b0);
                if (m_ack) ack_n++; else begin nack_n++; nack_at = tx_n; end
            end
        end else if ((scl === 1'b0) && (pscl === 1'b1) && (ph != PH_IDLE)) begin
            if (pcnt == 8 && (ph == PH_CTRL || ph == PH_WADDR)) begin
                if (ph == PH_CTRL) begin
                    ctrl_ack = (sh[7:1] == DEV) && present;
                    if (ctrl_n < 4) ctrl_log[ctrl_n] = sh;
                    ctrl_n++;
                    slave_low = ctrl_ack;
                end else slave_low = 1'b1;
            end else if (pcnt == 9) begin
                slave_low = 1'b0; pcnt = 0;
                case (ph)
                    PH_CTRL: if (!ctrl_ack) ph = PH_IDLE;
                             else if (sh[0]) begin ph = PH_TX; load_tx(); end
                             else ph = PH_WADDR;
                    PH_WADDR: begin ptr = sh; waddr_log = sh; ph = PH_IDLE; end
                    PH_TX: if (m_ack) load_tx(); else ph = PH_IDLE;
                    default: ;
                endcase
            end else if (ph == PH_TX && pcnt >= 1 && pcnt <= 7) begin
                slave_low = ~txb[7 - pcnt];
            end else if (ph == PH_TX && pcnt == 8) begin
                slave_low = 1'b0;
            end
        end
        psda = sda; pscl = scl;
    end

    // ---------------- register port monitor ----------------
    int   wr_cnt [NREG];
    logic [7:0] shadow [NREG];
    int   wr_total = 0, order_err = 0, last_wr = -1;

    always @(negedge clk) begin
        if (!rst && reg_we === 1'b1) begin
            if (int'(reg_addr) <= last_wr) order_err++;
            last_wr = int'(reg_addr);
            wr_cnt[reg_addr]++;
            shadow[reg_addr] = reg_wdata;
            wr_total++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        start_n = 0; stop_n = 0; ack_n = 0; nack_n = 0; nack_at = -1; tx_n = 0;
        ctrl_n = 0; waddr_log = 8'hFF; wr_total = 0; order_err = 0; last_wr = -1;
        for (int i = 0; i < NREG; i++) wr_cnt[i] = 0;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        clear_logs();
        rst = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        int t0 = cyc;
        while (done !== 1'b1 && (cyc - t0) < BOUND + 1000) @(negedge clk);
        cycles = cyc - t0;
    endtask

    task automatic check_image(input string tag);
        int bad = 0, lockw = 0;
        for (int a = 0; a < NREG; a++) begin
            bit locked = (a == ID_A) || (a >= ST_LO && a <= ST_HI);
            if (locked) begin if (wr_cnt[a] != 0) lockw++; end
            else if (wr_cnt[a] != 1 || shadow[a] !== img(a)) bad++;
        end
        chk(bad == 0, {tag, " R4 image bytes at matching addresses"}, bad, 0);
        chk(lockw == 0, {tag, " R5 locked addresses untouched"}, lockw, 0);
        chk(wr_total == NREG - 1 - (ST_HI - ST_LO + 1), {tag, " R5 write count"}, wr_total,
            NREG - 1 - (ST_HI - ST_LO + 1));
        chk(order_err == 0, {tag, " R4 ascending order"}, order_err, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset_state();
        @(negedge clk); rst = 1'b1; present = 1;
        repeat (3) @(negedge clk);
        chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
        chk(busy === 1'b0 && done === 1'b0 && no_eeprom === 1'b0, "R1 flags low in reset",
            {busy, done, no_eeprom}, 0);
        clear_logs();
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy === 1'b1, "R1 busy after reset release", busy, 1);
    endtask

    task automatic test_full_load();
        int cycles, t1, t2;
        // measure SCL period inside a data byte
        while (wr_total < 20) @(negedge clk);
        while (!(ph == PH_TX && pcnt == 2)) @(negedge clk);
        @(posedge scl); t1 = cyc;
        @(posedge scl); t2 = cyc;
        chk((t2 - t1) == 4 * QDIV, "R8 SCL period", t2 - t1, 4 * QDIV);
        wait_done(cycles);
        chk(done === 1'b1 && busy === 1'b0, "R7 done high busy low at end", {done, busy}, 2);
        chk(no_eeprom === 1'b0, "R6 no_eeprom stays low when present", no_eeprom, 0);
        chk(ctrl_n == 2 && ctrl_log[0] == 8'hA0 && ctrl_log[1] == 8'hA1, "R2 control bytes",
            ctrl_log[0], 8'hA0);
        chk(waddr_log == 8'h00, "R2 word address", waddr_log, 0);
        chk(start_n == 2 && stop_n == 1, "R3 start and stop count", start_n * 10 + stop_n, 21);
        chk(tx_n == NREG && ack_n == NREG - 1, "R3 bytes read and acked", ack_n, NREG - 1);
        chk(nack_n == 1 && nack_at == NREG, "R3 nack on last byte", nack_at, NREG);
        chk(cycles < BOUND, "R8 load time bound", cycles, BOUND);
        check_image("full");
    endtask

    task automatic test_done_holds();
        int w0 = wr_total;
        repeat (200) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R7 done sticky", {done, busy}, 2);
        chk(wr_total == w0, "R7 no writes after done", wr_total, w0);
        chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R7 bus idle after done", {scl_oe, sda_oe}, 0);
    endtask

    task automatic test_midload_reset();
        int cycles;
        present = 1;
        apply_reset();
        while (wr_total < 30) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R9 flags cleared by mid-load reset", {busy, done}, 0);
        clear_logs();
        for (int i = 0; i < NREG; i++) shadow[i] = 8'hEE;
        rst = 1'b0;
        wait_done(cycles);
        chk(done === 1'b1 && waddr_log == 8'h00 && ctrl_n == 2, "R9 reload from offset 0",
            ctrl_n, 2);
        check_image("reload R9");
    endtask

    task automatic test_no_device();
        int cycles;
        present = 0;
        apply_reset();
        wait_done(cycles);
        chk(done === 1'b1 && no_eeprom === 1'b1 && busy === 1'b0, "R6 absent flag and done",
            {done, no_eeprom, busy}, 6);
        chk(wr_total == 0, "R6 no register writes", wr_total, 0);
        chk(stop_n == 1 && ctrl_n == 1, "R6 stop after refused address", stop_n, 1);
        present = 1;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) shadow[i] = 8'hEE;
        test_reset_state();
        test_full_load();
        test_done_holds();
        test_midload_reset();
        test_no_device();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule